// File: doc/BRIEF.md
# Dual-Channel Power-Up Coordinator

This block decides, for two hot-swap power channels, the cycle in which each channel may begin its start-up and the cycle in which each must be switched off. Per channel it takes the input-voltage window flags (under- and over-voltage OK), an enable flag, a supply-lockout-OK flag, a fault flag and a busy flag from that channel's own start-up or cool-down sequencer. It also takes a global ON pin and per-channel register overrides for ON. It returns a level command per channel that stays high while the channel should be powered, plus one-cycle start and turn-off pulses. Gate drive and current regulation belong to other blocks.

The window and enable flags must stay valid for a debounce interval, given in clock ticks by a parameter, before a channel may start. In coupled mode the two channels start together and stop together. In independent mode each channel runs by itself, but the two are still kept from starting on top of each other's start-up or cool-down. After a fault, the channel either goes back to retry on its own or stays latched off until ON is raised again.

Top module: `hsw_pair_coord`

## Requirements
- R1: A channel's window/enable condition (uv_ok & ov_ok & en_ok for that index; index 0 is channel A) must be high for DEBOUNCE_TICKS consecutive rising edges. Any low cycle clears the count. With all other start terms met, run_cmd rises on edge DEBOUNCE_TICKS+1 after the condition is first sampled high.
- R2: The effective ON of a channel gates start-up. A running channel whose effective ON is low is turned off at the next edge.
- R3: When ovr_sel[i] is 1, channel i's effective ON is ovr_on[i]. When ovr_sel[i] is 0, it is on_pin.
- R4: With coupled_mode=1, channels start only in the same cycle, only when both have debounced and want ON, and only when neither seq_busy bit is set.
- R5: With coupled_mode=1, a fault or a lost start condition on either running channel turns both off at the next edge.
- R6: A fault with retry_en=0 latches the channel off. In coupled mode both channels latch. Only a rising edge of that channel's effective ON releases the latch. With retry_en=1, a faulted channel starts again once its own seq_busy is low.
- R7: A start needs both lock_ok bits high. A running channel whose own lock_ok falls is turned off at the next edge.
- R8: With coupled_mode=0, if one channel's condition rises while the other channel is still debouncing, the other channel's debounce restarts. Both then start in the same cycle.
- R9: A set seq_busy bit blocks every start at the next edge. In independent mode this covers the other channel's busy bit as well as the channel's own.
- R10: With coupled_mode=0, a fault on one channel leaves the other channel running.
- R11: A fault on a running channel turns it off at the next edge. Every start and every turn-off is marked by a one-cycle pulse on start_pulse or off_pulse. All outputs are low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coupled_mode | input | 1 | 1: channels start and stop together |
| retry_en | input | 1 | 1: auto-retry after fault, 0: latch off |
| on_pin | input | 1 | Global ON request |
| ovr_sel | input | 2 | Per channel: use register ON bit instead of pin |
| ovr_on | input | 2 | Per channel register ON bit |
| uv_ok | input | 2 | Input above undervoltage threshold |
| ov_ok | input | 2 | Input below overvoltage threshold |
| en_ok | input | 2 | Card enable present |
| lock_ok | input | 2 | Supply above lockout level |
| fault | input | 2 | Fault from the channel's protection logic |
| seq_busy | input | 2 | Channel sequencer in start-up or cool-down |
| run_cmd | output | 2 | Channel commanded on |
| start_pulse | output | 2 | One-cycle start command |
| off_pulse | output | 2 | One-cycle turn-off command |

## Verification
The bound checker watches several rules on every cycle:
- the debounce length before any start;
- shutdown after ON drops, after a fault or after coupled-mode trouble;
- the start cycles of the two channels matching in coupled mode;
- the busy and lockout gating of starts.

Some behaviours depend on history the checker does not rebuild, so only the bench's scenarios show them. These are the restart of one channel's debounce when the other channel becomes enabled, the latch being released by an ON rising edge, auto-retry after cool-down, and fault isolation in independent mode.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_ON    = 2'd1,
    CH_LATCH = 2'd2
  } ch_state_e;

  // Window and enable flags together form the debounced condition.
  function automatic logic inputs_valid(logic uv, logic ov, logic en);
    return uv & ov & en;
  endfunction

  // Register override selects between the ON bit and the shared pin.
  function automatic logic eff_on(logic sel, logic reg_on, logic pin);
    return sel ? reg_on : pin;
  endfunction

endpackage

// File: rtl/hsw_debounce.sv
module hsw_debounce #(
  parameter int unsigned TICKS = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic restart_i,
  output logic rise_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q;
  logic          cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond_i;
      if (!cond_i)
        cnt_q <= '0;
      else if (restart_i)
        cnt_q <= CW'(1);   // this cycle counts, aligned with the partner
      else if (cnt_q != LIMIT)
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign rise_o = cond_i & ~cond_q;
  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/hsw_start_arbiter.sv
module hsw_start_arbiter (
  input  logic       coupled_i,
  input  logic       retry_i,
  input  logic [1:0] want_i,
  input  logic [1:0] want_rise_i,
  input  logic [1:0] cond_i,
  input  logic [1:0] lock_i,
  input  logic [1:0] fault_i,
  input  logic [1:0] busy_i,
  input  logic [1:0] done_i,
  input  logic [1:0] on_i,
  input  logic [1:0] latch_i,
  output logic [1:0] go_start_o,
  output logic [1:0] go_off_o,
  output logic [1:0] go_latch_o,
  output logic [1:0] go_clear_o
);
  logic [1:0] lose, ready, idle;
  logic       both_start, any_lose, any_fault;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      idle[i]  = ~on_i[i] & ~latch_i[i];
      lose[i]  = ~want_i[i] | ~cond_i[i] | ~lock_i[i] | fault_i[i];
      ready[i] = idle[i] & done_i[i] & want_i[i] & (&lock_i)
               & ~busy_i[i] & ~fault_i[i];
    end
    both_start = ready[0] & ready[1] & ~(|busy_i);
    any_lose   = |(on_i & lose);
    any_fault  = |(on_i & fault_i);
    for (int i = 0; i < 2; i++) begin
      if (coupled_i) begin
        go_start_o[i] = both_start;
        go_off_o[i]   = on_i[i] & any_lose;
        go_latch_o[i] = on_i[i] & any_lose & any_fault & ~retry_i;
      end else begin
        go_start_o[i] = ready[i] & ~busy_i[1-i];
        go_off_o[i]   = on_i[i] & lose[i];
        go_latch_o[i] = on_i[i] & fault_i[i] & ~retry_i;
      end
      go_clear_o[i] = latch_i[i] & want_rise_i[i];
    end
  end
endmodule

// File: rtl/hsw_chan_fsm.sv
module hsw_chan_fsm
  import hsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_start_i,
  input  logic go_off_i,
  input  logic go_latch_i,
  input  logic go_clear_i,
  output logic run_o,
  output logic latched_o,
  output logic start_pulse_o,
  output logic off_pulse_o
);
  ch_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= CH_OFF;
      start_pulse_o <= 1'b0;
      off_pulse_o   <= 1'b0;
    end else begin
      start_pulse_o <= 1'b0;
      off_pulse_o   <= 1'b0;
      unique case (st_q)
        CH_OFF: if (go_start_i) begin
          st_q          <= CH_ON;
          start_pulse_o <= 1'b1;
        end
        CH_ON: if (go_off_i) begin
          st_q        <= go_latch_i ? CH_LATCH : CH_OFF;
          off_pulse_o <= 1'b1;
        end
        CH_LATCH: if (go_clear_i) st_q <= CH_OFF;
        default: st_q <= CH_OFF;
      endcase
    end
  end

  assign run_o     = (st_q == CH_ON);
  assign latched_o = (st_q == CH_LATCH);
endmodule

// File: rtl/hsw_pair_coord.sv
module hsw_pair_coord
  import hsw_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 25_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       coupled_mode,
  input  logic       retry_en,
  input  logic       on_pin,
  input  logic [1:0] ovr_sel,
  input  logic [1:0] ovr_on,
  input  logic [1:0] uv_ok,
  input  logic [1:0] ov_ok,
  input  logic [1:0] en_ok,
  input  logic [1:0] lock_ok,
  input  logic [1:0] fault,
  input  logic [1:0] seq_busy,
  output logic [1:0] run_cmd,
  output logic [1:0] start_pulse,
  output logic [1:0] off_pulse
);
  logic [1:0] cond, want, want_q, want_rise;
  logic [1:0] cond_rise, dbc_done, dbc_restart;
  logic [1:0] latched;
  logic [1:0] go_start, go_off, go_latch, go_clear;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      cond[i] = inputs_valid(uv_ok[i], ov_ok[i], en_ok[i]);
      want[i] = eff_on(ovr_sel[i], ovr_on[i], on_pin);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) want_q <= '0;
    else        want_q <= want;
  end
  assign want_rise = want & ~want_q;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    // Independent mode: partner becoming enabled restarts our debounce.
    assign dbc_restart[g] = ~coupled_mode & cond_rise[1-g] & cond[g]
                          & ~dbc_done[g];

    hsw_debounce #(.TICKS(DEBOUNCE_TICKS)) u_dbc (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond_i   (cond[g]),
      .restart_i(dbc_restart[g]),
      .rise_o   (cond_rise[g]),
      .done_o   (dbc_done[g])
    );

    hsw_chan_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_start_i   (go_start[g]),
      .go_off_i     (go_off[g]),
      .go_latch_i   (go_latch[g]),
      .go_clear_i   (go_clear[g]),
      .run_o        (run_cmd[g]),
      .latched_o    (latched[g]),
      .start_pulse_o(start_pulse[g]),
      .off_pulse_o  (off_pulse[g])
    );
  end

  hsw_start_arbiter u_arb (
    .coupled_i  (coupled_mode),
    .retry_i    (retry_en),
    .want_i     (want),
    .want_rise_i(want_rise),
    .cond_i     (cond),
    .lock_i     (lock_ok),
    .fault_i    (fault),
    .busy_i     (seq_busy),
    .done_i     (dbc_done),
    .on_i       (run_cmd),
    .latch_i    (latched),
    .go_start_o (go_start),
    .go_off_o   (go_off),
    .go_latch_o (go_latch),
    .go_clear_o (go_clear)
  );
endmodule

// File: rtl/hsw_pair_coord_chk.sv
module hsw_pair_coord_chk #(
  parameter int unsigned DEBOUNCE_TICKS = 25_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       coupled_mode,
  input logic       on_pin,
  input logic [1:0] ovr_sel,
  input logic [1:0] ovr_on,
  input logic [1:0] uv_ok,
  input logic [1:0] ov_ok,
  input logic [1:0] en_ok,
  input logic [1:0] lock_ok,
  input logic [1:0] fault,
  input logic [1:0] seq_busy,
  input logic [1:0] run_cmd,
  input logic [1:0] start_pulse
);
  localparam int unsigned CW = $clog2(DEBOUNCE_TICKS + 2);
  localparam logic [CW-1:0] SAT = CW'(DEBOUNCE_TICKS + 1);

  // R9
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|seq_busy) |=> (start_pulse == 2'b00));

  // R4
  coupled_same_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(coupled_mode) |-> (start_pulse[0] == start_pulse[1]));

  // R5
  coupled_fault_both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coupled_mode && (run_cmd == 2'b11) && (|fault)) |=> (run_cmd == 2'b00));

  for (genvar c = 0; c < 2; c++) begin : g_c
    logic [CW-1:0] held_q;
    logic          want_c;
    assign want_c = ovr_sel[c] ? ovr_on[c] : on_pin;

    always_ff @(posedge clk) begin
      if (!rst_n)                                held_q <= '0;
      else if (!(uv_ok[c] & ov_ok[c] & en_ok[c])) held_q <= '0;
      else if (held_q != SAT)                    held_q <= held_q + CW'(1);
    end

    // R1
    debounce_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[c] |-> (held_q == SAT));

    // R2
    on_low_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cmd[c] && !want_c) |=> !run_cmd[c]);

    // R7
    lockout_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[c] |-> $past(&lock_ok));

    // R11
    fault_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cmd[c] && fault[c]) |=> !run_cmd[c]);
  end
endmodule

bind hsw_pair_coord hsw_pair_coord_chk #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .coupled_mode(coupled_mode), .on_pin(on_pin),
  .ovr_sel(ovr_sel), .ovr_on(ovr_on), .uv_ok(uv_ok), .ov_ok(ov_ok),
  .en_ok(en_ok), .lock_ok(lock_ok), .fault(fault), .seq_busy(seq_busy),
  .run_cmd(run_cmd), .start_pulse(start_pulse)
);

// File: tb/sim_hsw_pair_coord.sv
module sim_hsw_pair_coord;
  localparam int unsigned DB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic coupled_mode = 0, retry_en = 0, on_pin = 0;
  logic [1:0] ovr_sel = 0, ovr_on = 0, uv_ok = 0, ov_ok = 0, en_ok = 0;
  logic [1:0] lock_ok = 0, fault = 0, seq_busy = 0;
  logic [1:0] run_cmd, start_pulse, off_pulse;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  hsw_pair_coord #(.DEBOUNCE_TICKS(DB)) u0 (.*);

  typedef struct packed {
    bit cpl; bit rty; bit pin;
    bit [1:0] osel; bit [1:0] oon; bit [1:0] uv; bit [1:0] ov; bit [1:0] en;
    bit [1:0] lk; bit [1:0] flt; bit [1:0] bsy;
    bit [7:0] wt; bit [1:0] ex; bit [3:0] rq;
  } vec_t;

  localparam int NV = 24;
  // exp bit 1 = channel B, bit 0 = channel A
  localparam vec_t TBL [NV] = '{
    '{0,1,0,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,8'd20,2'b00,4'd2},  // R2 idle
    '{0,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd20,2'b11,4'd1},  // R1 start
    '{0,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b01,2'b00,8'd1, 2'b10,4'd11}, // R11 fault A
    '{0,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b01,8'd20,2'b10,4'd9},  // R9 own busy
    '{0,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd3, 2'b11,4'd6},  // R6 retry
    '{0,1,0,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd2, 2'b00,4'd2},  // R2 pin low
    '{0,1,0,2'b01,2'b01,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd2, 2'b01,4'd3},  // R3 override on
    '{0,1,0,2'b11,2'b10,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd2, 2'b10,4'd3},  // R3 override off
    '{0,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b01,2'b00,2'b00,8'd20,2'b00,4'd7},  // R7 lockout B
    '{0,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd3, 2'b11,4'd7},  // R7 restore
    '{1,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b10,2'b00,8'd1, 2'b00,4'd5},  // R5 coupled fault
    '{1,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b10,8'd10,2'b00,4'd4},  // R4 B busy
    '{1,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd2, 2'b11,4'd4},  // R4 together
    '{1,1,1,2'b00,2'b00,2'b10,2'b11,2'b11,2'b11,2'b00,2'b00,8'd1, 2'b00,4'd5},  // R5 lost cond
    '{1,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd8, 2'b00,4'd1},  // R1 not yet
    '{1,1,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd1, 2'b11,4'd1},  // R1 exact
    '{1,0,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b01,2'b00,8'd1, 2'b00,4'd6},  // R6 latch both
    '{1,0,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd20,2'b00,4'd6},  // R6 stays
    '{1,0,0,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd2, 2'b00,4'd6},  // R6 pin low
    '{1,0,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd3, 2'b11,4'd6},  // R6 pin rise
    '{0,0,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b10,2'b00,8'd1, 2'b01,4'd10}, // R10 fault B
    '{0,0,1,2'b00,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd10,2'b01,4'd10}, // R10 isolated
    '{0,0,1,2'b10,2'b00,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd2, 2'b01,4'd6},  // R6 bit low
    '{0,0,1,2'b10,2'b10,2'b11,2'b11,2'b11,2'b11,2'b00,2'b00,8'd3, 2'b11,4'd6}   // R6 bit rise
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic base_in(input logic cpl);
    coupled_mode = cpl; retry_en = 1; on_pin = 1; ovr_sel = 0; ovr_on = 0;
    uv_ok = 0; ov_ok = 2'b11; en_ok = 2'b11; lock_ok = 2'b11;
    fault = 0; seq_busy = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(3);
    check("R11 reset run", run_cmd, 2'b00);
    check("R11 reset pulses", start_pulse | off_pulse, 2'b00);
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int k = 0; k < NV; k++) begin
      coupled_mode = TBL[k].cpl; retry_en = TBL[k].rty; on_pin = TBL[k].pin;
      ovr_sel = TBL[k].osel; ovr_on = TBL[k].oon; uv_ok = TBL[k].uv;
      ov_ok = TBL[k].ov; en_ok = TBL[k].en; lock_ok = TBL[k].lk;
      fault = TBL[k].flt; seq_busy = TBL[k].bsy;
      step(int'(TBL[k].wt));
      check($sformatf("R%0d vector %0d run_cmd", TBL[k].rq, k), run_cmd, TBL[k].ex);
    end

    // R1: a one-cycle drop during debounce restarts the count
    base_in(0); do_reset();
    uv_ok = 2'b01; step(5);
    uv_ok = 2'b00; step(1);
    uv_ok = 2'b01; step(DB);
    check("R1 drop restarts count", run_cmd, 2'b00);
    step(1);
    check("R1 start after full count", run_cmd, 2'b01);
    check("R11 start pulse", start_pulse, 2'b01);
    step(1);
    check("R11 start pulse one cycle", start_pulse, 2'b00);

    // R8: B enabled during A's debounce restarts A; both start together
    base_in(0); do_reset();
    uv_ok = 2'b01; step(3);
    uv_ok = 2'b11; step(DB);
    check("R8 A held by restart", run_cmd, 2'b00);
    step(1);
    check("R8 both start together", start_pulse, 2'b11);

    // R9: independent mode, B busy blocks A
    base_in(0); do_reset();
    uv_ok = 2'b11; seq_busy = 2'b10; step(20);
    check("R9 other busy blocks start", run_cmd, 2'b00);
    seq_busy = 2'b00; step(1);
    check("R9 start after busy clears", run_cmd, 2'b11);

    // R11: turn-off pulse
    on_pin = 0; step(1);
    check("R11 off pulse", off_pulse, 2'b11);
    check("R2 both off", run_cmd, 2'b00);
    step(1);
    check("R11 off pulse one cycle", off_pulse, 2'b00);

    finished = 1;
    summary();
    $finish;
  end
endmodule